// File: doc/BRIEF.md
# Fault Recovery Window Supervisor

This block sits beside a window watchdog. It lets a host processor that has reported its own hardware fault try to recover without being reset. Answer checking happens elsewhere and reaches this block only as a one-cycle good-refresh pulse. The block takes in the host's fault line through a synchronizer and applies a polarity chosen during initialization. It then decides which watchdog period is running: the normal one, or a longer recovery one that replaces it while a fault is flagged.

After reset, the supervisor waits in an initialization phase. The first good refresh closes that phase and starts fault monitoring. A flagged fault raises the fail-safe output, and the supervisor then enters the recovery period. If the host refreshes in time and the fault has gone, the normal period resumes and fail-safe drops. If the host refreshes while the fault is still present, a fresh recovery period starts. If no refresh arrives in time, the block drives a fixed-width reset pulse and returns to initialization.

The period lengths are cycle counts that the integrator supplies. The reset pulse width is a parameter.

Top module: `frw_supervisor`

## Requirements
- R1: After synchronous reset, init_phase is 1 and fs_assert, in_recovery, reset_pulse and wd_miss are 0.
- R2: While cfg_enable is 0, the supervisor stays in initialization: good refreshes and faults change none of the outputs.
- R3: Only a good refresh closes initialization. Until then, host faults are ignored and fs_assert stays 0.
- R4: Once monitoring is active, a fault on host_fault_in raises fs_assert on the third rising edge after the input changes. Two of those edges are synchronizer stages.
- R5: When the synchronized fault is present and fs_assert is 1 in the normal period, in_recovery rises at the next edge. A recovery window of cfg_recov_len cycles starts at that edge.
- R6: A good refresh during recovery with the fault cleared returns the supervisor to the normal period, and fs_assert falls at that same edge.
- R7: A good refresh during recovery while the fault persists keeps in_recovery and fs_assert high and restarts a full recovery window.
- R8: If no good refresh arrives within the recovery window, reset_pulse is high for RST_CYCLES cycles (default 4), fs_assert clears at its start, and init_phase returns when it ends.
- R9: Polarity is captured only during initialization. With cfg_fault_pol = 1 a high input is a fault; with 0 a low input is a fault. Changes made outside initialization have no effect.
- R10: In the normal period, a window of cfg_norm_len cycles with no good refresh gives exactly one wd_miss pulse, and a new window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Feature enable |
| cfg_fault_pol | input | 1 | Fault polarity, 1 = active high, captured in initialization |
| cfg_norm_len | input | CNT_W | Normal period length in cycles (at least 1) |
| cfg_recov_len | input | CNT_W | Recovery period length in cycles (at least 1) |
| host_fault_in | input | 1 | Asynchronous host fault line |
| good_refresh | input | 1 | One-cycle pulse for a correct watchdog answer |
| fs_assert | output | 1 | Fail-safe request |
| in_recovery | output | 1 | Recovery period running |
| init_phase | output | 1 | Initialization phase, monitoring inactive |
| reset_pulse | output | 1 | Reset request after failed recovery |
| wd_miss | output | 1 | Normal window ended without refresh |

## Verification
The assertions check the following on every cycle:
- Entry into recovery one edge after fault and fail-safe coincide.
- Fail-safe held throughout recovery.
- The exit to the normal period on a clean refresh.
- A reset pulse after an unanswered recovery window.
- The return to initialization when that pulse ends.
- The frozen polarity and the counter descending by one.

Only the bench scenarios show the following:
- The exact synchronizer latency seen at the pins.
- That faults before the first refresh leave no trace.
- The width of the reset pulse.
- That exactly one miss occurs per empty normal window.
- That polarity changes made after initialization are ignored.

// File: rtl/frw_pkg.sv
// Shared types for the fault recovery window supervisor.
package frw_pkg;

    // Supervisor phases; ST_NORMAL and ST_RECOV run the window timer.
    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_NORMAL = 2'd1,
        ST_RECOV  = 2'd2,
        ST_RESET  = 2'd3
    } frw_state_e;

    // True in the phases where a watchdog window is running.
    function automatic logic frw_window_running(frw_state_e s);
        return (s == ST_NORMAL) || (s == ST_RECOV);
    endfunction

endpackage

// File: rtl/frw_fault_sync.sv
// Synchronizes the asynchronous host fault line and applies polarity.
// Assumes STAGES >= 2. Polarity is loaded only while pol_load is high;
// otherwise the captured value is kept.
module frw_fault_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_raw,
    input  logic pol_load,
    input  logic pol_cfg,
    output logic fault_act
);

    logic [STAGES-1:0] sync_q;
    logic              pol_q;

    // Shift the raw line through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], fault_raw};
    end

    // Capture polarity while loading is allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)        pol_q <= 1'b1;
        else if (pol_load) pol_q <= pol_cfg;
    end

    assign fault_act = pol_q ? sync_q[STAGES-1] : ~sync_q[STAGES-1];

    // R9: polarity cannot move outside the load phase
    a_r9_pol_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_load |=> $stable(pol_q));

endmodule

// File: rtl/frw_window_timer.sv
// Down-counter for the watchdog windows. A load sets the window to
// load_len cycles (load_len >= 1); expired is high during the last
// cycle of a running window.
module frw_window_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             run,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new window or count the running one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= (load_len == '0) ? '0 : load_len - 1'b1;
        else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = run && (cnt_q == '0);

    // R10: a running window descends by one each cycle
    a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/frw_reset_gen.sv
// Fixed-width reset pulse timer. start begins a pulse of RST_CYCLES
// cycles; done marks its final cycle. Assumes RST_CYCLES >= 1.
module frw_reset_gen #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    // Run the pulse counter from start until it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CW'(RST_CYCLES - 1);
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = busy && (cnt_q == '0);

    // R8: the pulse keeps going until its last cycle
    a_r8_width_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !start) |=> busy);

endmodule

// File: rtl/frw_supervisor.sv
// Fault recovery window supervisor. Chooses between the normal and
// recovery watchdog periods from the synchronized host fault, drives
// fail-safe and issues a reset pulse when recovery is not confirmed.
// Assumes good_refresh is a single-cycle pulse synchronous to clk and
// that the configured lengths are static while a window runs.
module frw_supervisor
    import frw_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SYNC_STAGE = 2,
    parameter int RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             cfg_fault_pol,
    input  logic [CNT_W-1:0] cfg_norm_len,
    input  logic [CNT_W-1:0] cfg_recov_len,
    input  logic             host_fault_in,
    input  logic             good_refresh,
    output logic             fs_assert,
    output logic             in_recovery,
    output logic             init_phase,
    output logic             reset_pulse,
    output logic             wd_miss
);

    frw_state_e       state_q, state_d;
    logic             fs_q, fs_d;
    logic             fault_act;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_len;
    logic             rst_start, rst_busy, rst_done;
    logic             miss;

    frw_fault_sync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_raw (host_fault_in),
        .pol_load  (state_q == ST_INIT),
        .pol_cfg   (cfg_fault_pol),
        .fault_act (fault_act)
    );

    frw_window_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_len (tmr_len),
        .run      (frw_window_running(state_q)),
        .expired  (tmr_expired)
    );

    frw_reset_gen #(.RST_CYCLES(RST_CYCLES)) u_rstgen (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rst_start),
        .busy  (rst_busy),
        .done  (rst_done)
    );

    // Next phase, window reloads and pulse requests.
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_len   = cfg_norm_len;
        rst_start = 1'b0;
        miss      = 1'b0;
        case (state_q)
            ST_INIT: begin
                if (good_refresh) begin
                    state_d  = ST_NORMAL;
                    tmr_load = 1'b1;
                end
            end
            ST_NORMAL: begin
                if (fault_act && fs_q) begin
                    state_d  = ST_RECOV;
                    tmr_load = 1'b1;
                    tmr_len  = cfg_recov_len;
                end else if (good_refresh) begin
                    tmr_load = 1'b1;
                end else if (tmr_expired) begin
                    tmr_load = 1'b1;
                    miss     = 1'b1;
                end
            end
            ST_RECOV: begin
                if (good_refresh) begin
                    tmr_load = 1'b1;
                    if (fault_act) tmr_len = cfg_recov_len;
                    else           state_d = ST_NORMAL;
                end else if (tmr_expired) begin
                    state_d   = ST_RESET;
                    rst_start = 1'b1;
                end
            end
            ST_RESET: begin
                if (rst_done) state_d = ST_INIT;
            end
            default: state_d = ST_INIT;
        endcase
        if (!cfg_enable) begin
            state_d   = ST_INIT;
            tmr_load  = 1'b0;
            rst_start = 1'b0;
            miss      = 1'b0;
        end
    end

    // Next fail-safe level: cleared on leaving monitoring or clean recovery.
    always_comb begin
        fs_d = fs_q;
        if (state_d == ST_INIT || state_d == ST_RESET)
            fs_d = 1'b0;
        else if (state_q == ST_RECOV && state_d == ST_NORMAL)
            fs_d = 1'b0;
        else if (frw_window_running(state_q) && fault_act)
            fs_d = 1'b1;
    end

    // Register phase and fail-safe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            fs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            fs_q    <= fs_d;
        end
    end

    assign fs_assert   = fs_q;
    assign in_recovery = (state_q == ST_RECOV);
    assign init_phase  = (state_q == ST_INIT);
    assign reset_pulse = (state_q == ST_RESET);
    assign wd_miss     = miss;

    // R2: disabled feature falls back to initialization
    a_r2_disabled_init: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> init_phase);

    // R3: initialization ends only on a good refresh
    a_r3_init_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (init_phase && !good_refresh) |=> init_phase);

    // R4: recovery never runs without fail-safe
    a_r4_recovery_has_fs: assert property (@(posedge clk) disable iff (!rst_n)
        in_recovery |-> fs_assert);

    // R5: fault plus fail-safe in the normal period enters recovery
    a_r5_enter_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && fault_act && fs_q && cfg_enable) |=> in_recovery);

    // R6: clean refresh during recovery restores the normal period
    a_r6_clean_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recovery && good_refresh && !fault_act && cfg_enable)
        |=> (state_q == ST_NORMAL && !fs_assert));

    // R8: unanswered recovery window starts the reset pulse
    a_r8_expire_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recovery && tmr_expired && !good_refresh && cfg_enable) |=> reset_pulse);

    // R8: the reset pulse hands over to initialization
    a_r8_pulse_to_init: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_pulse) |-> init_phase);

    // R8: pulse timer runs while the reset phase is active
    a_r8_busy_match: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> rst_busy);

endmodule

// File: tb/frw_supervisor_bench.sv
module frw_supervisor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int NORM_LEN   = 20;
    localparam int RECOV_LEN  = 12;
    localparam int WD_CYCLES  = 20000;

    // Vector: {fault, refresh, wait[7:0], exp {init, rec, fs, rst}}
    localparam int NVEC = 12;
    localparam logic [13:0] VEC [0:NVEC-1] = '{
        {1'b0, 1'b1, 8'd1,  4'b0000},  // 0  R3 first refresh closes init
        {1'b1, 1'b0, 8'd4,  4'b0110},  // 1  R4 R5 fault -> fs -> recovery
        {1'b1, 1'b1, 8'd1,  4'b0110},  // 2  R7 refresh, fault persists
        {1'b0, 1'b0, 8'd3,  4'b0110},  // 3  R7 still recovering
        {1'b0, 1'b1, 8'd1,  4'b0000},  // 4  R6 clean refresh -> normal
        {1'b1, 1'b0, 8'd4,  4'b0110},  // 5  R5 recovery again
        {1'b1, 1'b0, 8'd11, 4'b0001},  // 6  R8 window runs out -> pulse
        {1'b0, 1'b0, 8'd3,  4'b1000},  // 7  R8 pulse over -> init
        {1'b1, 1'b0, 8'd6,  4'b1000},  // 8  R3 fault ignored in init
        {1'b0, 1'b0, 8'd3,  4'b1000},  // 9  R3 still init
        {1'b0, 1'b1, 8'd1,  4'b0000},  // 10 R3 refresh closes init
        {1'b0, 1'b0, 8'd5,  4'b0000}   // 11 R10 normal period steady
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_enable = 1'b1;
    logic             cfg_fault_pol = 1'b1;
    logic [CNT_W-1:0] cfg_norm_len = CNT_W'(NORM_LEN);
    logic [CNT_W-1:0] cfg_recov_len = CNT_W'(RECOV_LEN);
    logic             host_fault_in = 1'b0;
    logic             good_refresh = 1'b0;
    logic             fs_assert, in_recovery, init_phase, reset_pulse, wd_miss;

    int checks = 0;
    int errors = 0;

    frw_supervisor #(.CNT_W(CNT_W), .SYNC_STAGE(2), .RST_CYCLES(4)) u_frw_supervisor (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_enable    (cfg_enable),
        .cfg_fault_pol (cfg_fault_pol),
        .cfg_norm_len  (cfg_norm_len),
        .cfg_recov_len (cfg_recov_len),
        .host_fault_in (host_fault_in),
        .good_refresh  (good_refresh),
        .fs_assert     (fs_assert),
        .in_recovery   (in_recovery),
        .init_phase    (init_phase),
        .reset_pulse   (reset_pulse),
        .wd_miss       (wd_miss)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string vec_tag(int i);
        case (i)
            0, 8, 9, 10: return "R3";
            1:           return "R4/R5";
            2, 3:        return "R7";
            4:           return "R6";
            5:           return "R5";
            6, 7:        return "R8";
            default:     return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {init,rec,fs,rst,miss} actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {init_phase, in_recovery, fs_assert, reset_pulse, wd_miss};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        good_refresh = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive fault level and optional refresh pulse, wait, then check.
    task automatic step(logic flt, logic refr, int nwait, logic [3:0] exp, string tag);
        host_fault_in = flt;
        good_refresh  = refr;
        @(negedge clk);
        good_refresh  = 1'b0;
        repeat (nwait) @(negedge clk);
        check(tag, outs(), {exp, 1'b0});
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1", outs(), 5'b10000);

        for (int i = 0; i < NVEC; i++)
            step(VEC[i][13], VEC[i][12], int'(VEC[i][11:4]), VEC[i][3:0], vec_tag(i));

        // R10: empty normal window gives exactly one miss
        begin
            int misses = 0;
            do_reset();
            repeat (3) @(negedge clk);
            good_refresh = 1'b1;
            @(negedge clk);
            good_refresh = 1'b0;
            for (int k = 0; k <= NORM_LEN; k++) begin
                if (wd_miss) misses++;
                @(negedge clk);
            end
            check("R10", {4'b0000, misses == 1}, 5'b00001);
            check("R10", outs(), 5'b00000);
        end

        // R9: active-low polarity captured during init
        cfg_fault_pol = 1'b0;
        host_fault_in = 1'b1;
        do_reset();
        repeat (3) @(negedge clk);
        step(1'b1, 1'b1, 3, 4'b0000, "R9");
        step(1'b0, 1'b0, 4, 4'b0110, "R9");

        // R9: polarity change after init has no effect
        cfg_fault_pol = 1'b1;
        host_fault_in = 1'b0;
        do_reset();
        repeat (3) @(negedge clk);
        step(1'b0, 1'b1, 1, 4'b0000, "R9");
        cfg_fault_pol = 1'b0;
        step(1'b0, 1'b0, 6, 4'b0000, "R9");
        cfg_fault_pol = 1'b1;

        // R2: disabled feature ignores refresh and faults
        cfg_enable = 1'b0;
        do_reset();
        step(1'b0, 1'b1, 2, 4'b1000, "R2");
        step(1'b1, 1'b1, 5, 4'b1000, "R2");
        cfg_enable = 1'b1;
        host_fault_in = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule